// File: doc/BRIEF.md
# Message-Signalled Interrupt Aggregator

The aggregator gathers up to 32 level interrupt lines from the peripherals of a multi-function I/O chip. Every rising edge on a line is latched as a pending bit. When the mask bit of that line is set, the event is sent to the processor as one 32-bit memory write on a master request port, not as a wire. The address of that write is a programmable interrupt-address register with its low five bits forced to zero. The data is those five low bits.

Software reaches the block through a big-endian register slave port. An access carries 1 to 4 bytes and must not cross a 32-bit word. The slave port gives access to the line levels, the mask, the pending set, a control word, the interrupt address, and a small group of system registers. Reading the pending register clears it, and so does writing it. Setting the bus-error bit in the control word stops delivery. Deliveries go out one at a time, lowest source first.

Top module: `irq_msg_agg`

## Requirements
- R1: After reset, the mask (0x04), pending (0x08) and control (0x0C) registers read zero. The interrupt address (0x10) reads the value of parameter IAR_RST, and no delivery write is requested.
- R2: An access carries `req_size_i` bytes, from 1 to 4. The bytes are taken from the word at `req_addr_i & ~3`, starting at byte offset `req_addr_i[1:0]`. Byte offset 0 is bits 31:24. Data is right-aligned in `req_wdata_i` and `rsp_rdata_o`, and a write changes only the addressed bytes.
- R3: An access is rejected with `rsp_err_o`=1, read data 0 and no effect on any register when its offset is not decoded, its size is 0 or above 4, or it crosses a word.
- R4: Offset 0x00 reads the registered level of each source line. Writes to it have no effect.
- R5: A rising edge on `src_i[n]` sets pending bit n, whatever the mask holds.
- R6: Any read of the pending register returns its value and then clears it. Any write clears it, whatever the data.
- R7: A mask write always stores the merged value. `mask_warn_o` pulses with the response when that value has a bit outside parameter MASK_VALID (bits 5, 7, 8, 9, 13, 14, 16 to 21 by default) and is not 0xFFFFFFFF.
- R8: A control read returns bit 8 (bus error) only, with every other bit zero. A control write with bit 1 set gives a one-cycle `toc_o` pulse with the response.
- R9: A rising edge on source n requests one write of address `iar & ~31` and data `iar & 31`. This happens only if mask bit n is set and control bit 8 is clear when the write is issued. Otherwise the event is dropped.
- R10: Only one delivery write is outstanding at a time. Among waiting events the lowest source number is issued first. `wr_valid_o`, `wr_addr_o` and `wr_data_o` hold until `wr_ready_i`.
- R11: Offset 0xC008 (version) and 0xC00C (I/O reset) read 0 and ignore writes. Offsets 0xC000, 0xC004 and 0xC010 are plain 32-bit read/write storage.
- R12: Every request gets exactly one response, with `rsp_valid_o` high in the cycle after the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | 32 | Synchronous level interrupt lines |
| req_valid_i | input | 1 | Register access request |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | ADDR_W | Byte offset within the block |
| req_size_i | input | 3 | Access size in bytes |
| req_wdata_i | input | 32 | Write data, right-aligned |
| rsp_valid_o | output | 1 | Response strobe |
| rsp_err_o | output | 1 | Access rejected |
| rsp_rdata_o | output | 32 | Read data, right-aligned |
| mask_warn_o | output | 1 | Mask write held out-of-range bits |
| toc_o | output | 1 | Transfer-of-control request pulse |
| wr_valid_o | output | 1 | Delivery write request |
| wr_ready_i | input | 1 | Delivery write accepted |
| wr_addr_o | output | 32 | Delivery write address |
| wr_data_o | output | 32 | Delivery write data |

## Verification
A wrong pending or queued bit shows up at the ports in one of two ways. It shows as a wrong register read one cycle after the access. It also shows as a missing or extra delivery write two cycles after the source edge, because the edge is registered once and the issue is registered once. The ordering test keeps a delivery held while two more events wait. It then masks out the higher source, so a scan that picked the wrong source first would produce one extra write that can be seen. A lane-alignment fault shows up in the very next read of a known pattern at each byte offset.

// File: rtl/irq_msg_pkg.sv
package irq_msg_pkg;
  localparam int unsigned DW    = 32;
  localparam int unsigned IDX_W = $clog2(DW);

  localparam logic [31:0] OFS_LVL   = 32'h0000_0000;
  localparam logic [31:0] OFS_MASK  = 32'h0000_0004;
  localparam logic [31:0] OFS_PEND  = 32'h0000_0008;
  localparam logic [31:0] OFS_CTL   = 32'h0000_000C;
  localparam logic [31:0] OFS_IAR   = 32'h0000_0010;
  localparam logic [31:0] OFS_PWR   = 32'h0000_C000;
  localparam logic [31:0] OFS_ELOG  = 32'h0000_C004;
  localparam logic [31:0] OFS_VER   = 32'h0000_C008;
  localparam logic [31:0] OFS_IORST = 32'h0000_C00C;
  localparam logic [31:0] OFS_ARB   = 32'h0000_C010;

  localparam int unsigned CTL_BLK_BIT = 8;
  localparam int unsigned CTL_TOC_BIT = 1;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_LVL, SEL_MASK, SEL_PEND, SEL_CTL, SEL_IAR,
    SEL_PWR, SEL_ELOG, SEL_VER, SEL_IORST, SEL_ARB
  } reg_sel_e;
endpackage

// File: rtl/irq_lane_align.sv
module irq_lane_align
  import irq_msg_pkg::*;
#(
  parameter int unsigned ADDR_W = 20
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [2:0]        size_i,
  output reg_sel_e          sel_o,
  output logic              ok_o,
  output logic [4:0]        shift_o,
  output logic [DW-1:0]     lane_o
);
  logic [ADDR_W-1:0] word_a;
  logic [3:0]        end_b, rem_b;
  logic              size_ok;
  logic [DW-1:0]     base_m;

  assign word_a  = {addr_i[ADDR_W-1:2], 2'b00};
  assign end_b   = {2'b00, addr_i[1:0]} + {1'b0, size_i};
  assign size_ok = (size_i != 3'd0) && (size_i <= 3'd4) && (end_b <= 4'd4);
  assign rem_b   = 4'd4 - end_b;
  assign shift_o = {rem_b[1:0], 3'b000};

  always_comb begin
    unique case (size_i)
      3'd1:    base_m = 32'h0000_00FF;
      3'd2:    base_m = 32'h0000_FFFF;
      3'd3:    base_m = 32'h00FF_FFFF;
      3'd4:    base_m = 32'hFFFF_FFFF;
      default: base_m = '0;
    endcase
  end
  assign lane_o = base_m << shift_o;

  always_comb begin
    if      (word_a == ADDR_W'(OFS_LVL))   sel_o = SEL_LVL;
    else if (word_a == ADDR_W'(OFS_MASK))  sel_o = SEL_MASK;
    else if (word_a == ADDR_W'(OFS_PEND))  sel_o = SEL_PEND;
    else if (word_a == ADDR_W'(OFS_CTL))   sel_o = SEL_CTL;
    else if (word_a == ADDR_W'(OFS_IAR))   sel_o = SEL_IAR;
    else if (word_a == ADDR_W'(OFS_PWR))   sel_o = SEL_PWR;
    else if (word_a == ADDR_W'(OFS_ELOG))  sel_o = SEL_ELOG;
    else if (word_a == ADDR_W'(OFS_VER))   sel_o = SEL_VER;
    else if (word_a == ADDR_W'(OFS_IORST)) sel_o = SEL_IORST;
    else if (word_a == ADDR_W'(OFS_ARB))   sel_o = SEL_ARB;
    else                                   sel_o = SEL_NONE;
  end

  assign ok_o = size_ok && (sel_o != SEL_NONE);
endmodule

// File: rtl/irq_src_track.sv
module irq_src_track
  import irq_msg_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [DW-1:0] src_i,
  input  logic          clr_pend_i,
  output logic [DW-1:0] lvl_o,
  output logic [DW-1:0] pend_o,
  output logic [DW-1:0] rise_o
);
  logic [DW-1:0] lvl_q, pend_q;

  assign rise_o = src_i & ~lvl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q  <= '0;
      pend_q <= '0;
    end else begin
      lvl_q  <= src_i;
      // a new edge in the clearing cycle survives
      pend_q <= (clr_pend_i ? '0 : pend_q) | rise_o;
    end
  end

  assign lvl_o  = lvl_q;
  assign pend_o = pend_q;
endmodule

// File: rtl/irq_msg_send.sv
module irq_msg_send
  import irq_msg_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [DW-1:0] rise_i,
  input  logic [DW-1:0] mask_i,
  input  logic          block_i,
  input  logic [31:0]   iar_i,
  output logic          wr_valid_o,
  input  logic          wr_ready_i,
  output logic [31:0]   wr_addr_o,
  output logic [31:0]   wr_data_o
);
  logic [DW-1:0] wait_q, cand, drop, take;
  logic          found, busy_q, issue;
  logic [31:0]   addr_q, data_q;

  assign cand = block_i ? '0 : (wait_q & mask_i);
  assign drop = wait_q & ~cand;

  always_comb begin
    take  = '0;
    found = 1'b0;
    for (int i = DW - 1; i >= 0; i--) begin
      if (cand[i]) begin
        take    = '0;
        take[i] = 1'b1;
        found   = 1'b1;
      end
    end
  end

  assign issue = found && !busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wait_q <= '0;
      busy_q <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      wait_q <= (wait_q & ~drop & ~(issue ? take : '0)) | rise_i;
      if (issue) begin
        busy_q <= 1'b1;
        addr_q <= {iar_i[31:5], 5'b00000};
        data_q <= {27'd0, iar_i[4:0]};
      end else if (busy_q && wr_ready_i) begin
        busy_q <= 1'b0;
      end
    end
  end

  assign wr_valid_o = busy_q;
  assign wr_addr_o  = addr_q;
  assign wr_data_o  = data_q;
endmodule

// File: rtl/irq_msg_agg.sv
module irq_msg_agg
  import irq_msg_pkg::*;
#(
  parameter int unsigned ADDR_W     = 20,
  parameter logic [31:0] IAR_RST    = 32'h0000_F003,
  parameter logic [31:0] MASK_VALID = 32'h003F_63A0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [31:0]       src_i,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [2:0]        req_size_i,
  input  logic [31:0]       req_wdata_i,
  output logic              rsp_valid_o,
  output logic              rsp_err_o,
  output logic [31:0]       rsp_rdata_o,
  output logic              mask_warn_o,
  output logic              toc_o,
  output logic              wr_valid_o,
  input  logic              wr_ready_i,
  output logic [31:0]       wr_addr_o,
  output logic [31:0]       wr_data_o
);
  reg_sel_e      sel;
  logic          ok, acc, do_wr, do_rd, clr_pend;
  logic [4:0]    shift;
  logic [DW-1:0] lane, cur, merged, lvl, pend, rise;
  logic [DW-1:0] mask_q, iar_q, pwr_q, elog_q, arb_q;
  logic          blk_q;
  logic          rsp_v_q, rsp_e_q, warn_q, toc_q;
  logic [DW-1:0] rdata_q;

  irq_lane_align #(.ADDR_W(ADDR_W)) u_align (
    .addr_i  (req_addr_i),
    .size_i  (req_size_i),
    .sel_o   (sel),
    .ok_o    (ok),
    .shift_o (shift),
    .lane_o  (lane)
  );

  assign acc      = req_valid_i && ok;
  assign do_wr    = acc && req_write_i;
  assign do_rd    = acc && !req_write_i;
  assign clr_pend = acc && (sel == SEL_PEND);

  irq_src_track u_track (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .src_i      (src_i),
    .clr_pend_i (clr_pend),
    .lvl_o      (lvl),
    .pend_o     (pend),
    .rise_o     (rise)
  );

  irq_msg_send u_send (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rise_i     (rise),
    .mask_i     (mask_q),
    .block_i    (blk_q),
    .iar_i      (iar_q),
    .wr_valid_o (wr_valid_o),
    .wr_ready_i (wr_ready_i),
    .wr_addr_o  (wr_addr_o),
    .wr_data_o  (wr_data_o)
  );

  always_comb begin
    cur = '0;
    unique case (sel)
      SEL_LVL:  cur = lvl;
      SEL_MASK: cur = mask_q;
      SEL_PEND: cur = pend;
      SEL_CTL:  cur[CTL_BLK_BIT] = blk_q;
      SEL_IAR:  cur = iar_q;
      SEL_PWR:  cur = pwr_q;
      SEL_ELOG: cur = elog_q;
      SEL_ARB:  cur = arb_q;
      default:  cur = '0;
    endcase
  end

  assign merged = (cur & ~lane) | ((req_wdata_i << shift) & lane);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '0;
      blk_q  <= 1'b0;
      iar_q  <= IAR_RST;
      pwr_q  <= '0;
      elog_q <= '0;
      arb_q  <= '0;
    end else if (do_wr) begin
      unique case (sel)
        SEL_MASK: mask_q <= merged;
        SEL_CTL:  blk_q  <= merged[CTL_BLK_BIT];
        SEL_IAR:  iar_q  <= merged;
        SEL_PWR:  pwr_q  <= merged;
        SEL_ELOG: elog_q <= merged;
        SEL_ARB:  arb_q  <= merged;
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_v_q <= 1'b0;
      rsp_e_q <= 1'b0;
      rdata_q <= '0;
      warn_q  <= 1'b0;
      toc_q   <= 1'b0;
    end else begin
      rsp_v_q <= req_valid_i;
      rsp_e_q <= req_valid_i && !ok;
      rdata_q <= do_rd ? ((cur & lane) >> shift) : '0;
      warn_q  <= do_wr && (sel == SEL_MASK) &&
                 ((merged & ~MASK_VALID) != '0) && (merged != '1);
      toc_q   <= do_wr && (sel == SEL_CTL) && merged[CTL_TOC_BIT];
    end
  end

  assign rsp_valid_o = rsp_v_q;
  assign rsp_err_o   = rsp_e_q;
  assign rsp_rdata_o = rdata_q;
  assign mask_warn_o = warn_q;
  assign toc_o       = toc_q;
endmodule

// File: rtl/irq_msg_agg_chk.sv
module irq_msg_agg_chk
  import irq_msg_pkg::*;
#(
  parameter int unsigned ADDR_W = 20
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic              req_write_i,
  input logic [ADDR_W-1:0] req_addr_i,
  input logic [2:0]        req_size_i,
  input logic              rsp_valid_o,
  input logic              rsp_err_o,
  input logic [31:0]       rsp_rdata_o,
  input logic              mask_warn_o,
  input logic              wr_valid_o,
  input logic              wr_ready_i,
  input logic [31:0]       wr_addr_o,
  input logic [31:0]       wr_data_o
);
  localparam logic [ADDR_W-1:0] VER_A  = ADDR_W'(OFS_VER);
  localparam logic [ADDR_W-1:0] CTL_A  = ADDR_W'(OFS_CTL);
  localparam logic [ADDR_W-1:0] MASK_A = ADDR_W'(OFS_MASK);

  AST_RSP_NEXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o); // R12
  AST_RSP_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !rsp_valid_o); // R12
  AST_BAD_SIZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_size_i == 3'd0) |=> (rsp_err_o && rsp_rdata_o == '0)); // R3
  AST_VER_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !req_write_i && req_addr_i[ADDR_W-1:2] == VER_A[ADDR_W-1:2])
    |=> (rsp_rdata_o == '0)); // R11
  AST_CTL_ONLY_BLK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !req_write_i && req_addr_i == CTL_A && req_size_i == 3'd4)
    |=> ((rsp_rdata_o & 32'hFFFF_FEFF) == '0)); // R8
  AST_WARN_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_valid_i && req_write_i && req_addr_i[ADDR_W-1:2] == MASK_A[ADDR_W-1:2])
    |=> !mask_warn_o); // R7
  AST_WR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_o && !wr_ready_i)
    |=> (wr_valid_o && $stable(wr_addr_o) && $stable(wr_data_o))); // R10
  AST_WR_SPLIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_o |-> (wr_addr_o[4:0] == 5'd0 && wr_data_o[31:5] == '0)); // R9
endmodule

bind irq_msg_agg irq_msg_agg_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_write_i (req_write_i),
  .req_addr_i  (req_addr_i),
  .req_size_i  (req_size_i),
  .rsp_valid_o (rsp_valid_o),
  .rsp_err_o   (rsp_err_o),
  .rsp_rdata_o (rsp_rdata_o),
  .mask_warn_o (mask_warn_o),
  .wr_valid_o  (wr_valid_o),
  .wr_ready_i  (wr_ready_i),
  .wr_addr_o   (wr_addr_o),
  .wr_data_o   (wr_data_o)
);

// File: tb/irq_msg_agg_bench.sv
module irq_msg_agg_bench;
  localparam int AW = 20;
  localparam logic [31:0] IAR_DEF = 32'h0000_F003;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst_n;
  logic [31:0]   src;
  logic          req_valid, req_write;
  logic [AW-1:0] req_addr;
  logic [2:0]    req_size;
  logic [31:0]   req_wdata;
  logic          rsp_valid, rsp_err, mask_warn, toc;
  logic [31:0]   rsp_rdata;
  logic          wr_valid, wr_ready;
  logic [31:0]   wr_addr, wr_data;

  int checks = 0;
  int errors = 0;
  logic [63:0] exp_q[$];

  irq_msg_agg #(.ADDR_W(AW), .IAR_RST(IAR_DEF)) u_irq_msg_agg (
    .clk_i(clk), .rst_ni(rst_n), .src_i(src),
    .req_valid_i(req_valid), .req_write_i(req_write), .req_addr_i(req_addr),
    .req_size_i(req_size), .req_wdata_i(req_wdata),
    .rsp_valid_o(rsp_valid), .rsp_err_o(rsp_err), .rsp_rdata_o(rsp_rdata),
    .mask_warn_o(mask_warn), .toc_o(toc),
    .wr_valid_o(wr_valid), .wr_ready_i(wr_ready),
    .wr_addr_o(wr_addr), .wr_data_o(wr_data)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic access(input logic wr, input logic [AW-1:0] a, input logic [2:0] sz,
                        input logic [31:0] wd, output logic [31:0] rd,
                        output logic er, output logic wn, output logic tc);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_size = sz; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    rd = rsp_rdata; er = rsp_err; wn = mask_warn; tc = toc;
    check("R12 rsp_valid", {31'd0, rsp_valid}, 32'd1);
  endtask

  task automatic rd_chk(input logic [AW-1:0] a, input logic [2:0] sz,
                        input logic [31:0] exp, input string tag);
    logic [31:0] rd; logic er, wn, tc;
    access(1'b0, a, sz, 32'd0, rd, er, wn, tc);
    check(tag, rd, exp);
  endtask

  task automatic wr_reg(input logic [AW-1:0] a, input logic [2:0] sz, input logic [31:0] d);
    logic [31:0] rd; logic er, wn, tc;
    access(1'b1, a, sz, d, rd, er, wn, tc);
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  // scoreboard monitor: one pop per accepted delivery
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (rst_n && wr_valid && wr_ready) begin
        if (exp_q.size() == 0) begin
          checks++; errors++;
          $display("FAIL R9/R10: unexpected write actual %h/%h expected none", wr_addr, wr_data);
        end else begin
          logic [63:0] e;
          e = exp_q.pop_front();
          check("R9 addr", wr_addr, e[63:32]);
          check("R9 data", wr_data, e[31:0]);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] rd; logic er, wn, tc;
    rst_n = 1'b0; src = '0; req_valid = 1'b0; req_write = 1'b0;
    req_addr = '0; req_size = 3'd4; req_wdata = '0; wr_ready = 1'b1;
    cycles(3);
    rst_n = 1'b1;

    // R1 reset state
    check("R1 wr_valid", {31'd0, wr_valid}, 32'd0);
    rd_chk('h10, 3'd4, IAR_DEF, "R1 iar");
    rd_chk('h04, 3'd4, 32'd0, "R1 mask");
    rd_chk('h08, 3'd4, 32'd0, "R1 pend");
    rd_chk('h0C, 3'd4, 32'd0, "R1 ctl");

    // R2 big-endian lanes
    wr_reg('h10, 3'd4, 32'h1122_3344);
    rd_chk('h10, 3'd1, 32'h11, "R2 byte0");
    rd_chk('h13, 3'd1, 32'h44, "R2 byte3");
    rd_chk('h12, 3'd2, 32'h3344, "R2 half");
    wr_reg('h11, 3'd1, 32'hAB);
    rd_chk('h10, 3'd4, 32'h11AB_3344, "R2 merge");
    rd_chk('h11, 3'd3, 32'hAB_3344, "R2 tri");
    wr_reg('h10, 3'd4, IAR_DEF);

    // R3 rejected accesses
    access(1'b0, 'h14, 3'd4, 0, rd, er, wn, tc);
    check("R3 undecoded err", {31'd0, er}, 32'd1);
    check("R3 undecoded data", rd, 32'd0);
    access(1'b0, 'h12, 3'd4, 0, rd, er, wn, tc);
    check("R3 cross err", {31'd0, er}, 32'd1);
    access(1'b0, 'h10, 3'd0, 0, rd, er, wn, tc);
    check("R3 size0 err", {31'd0, er}, 32'd1);
    access(1'b1, 'h12, 3'd4, 32'h0, rd, er, wn, tc);
    check("R3 cross write err", {31'd0, er}, 32'd1);
    rd_chk('h10, 3'd4, IAR_DEF, "R3 no effect");

    // R4 line levels, read-only
    src[13] = 1'b1; cycles(2);
    rd_chk('h00, 3'd4, 32'h0000_2000, "R4 level");
    wr_reg('h00, 3'd4, 32'hFFFF_FFFF);
    rd_chk('h00, 3'd4, 32'h0000_2000, "R4 write ignored");
    src[13] = 1'b0; cycles(2);
    rd_chk('h00, 3'd4, 32'd0, "R4 level low");

    // R5 / R6 pending
    rd_chk('h08, 3'd4, 32'h0000_2000, "R5 pend set unmasked");
    rd_chk('h08, 3'd4, 32'd0, "R6 read clears");
    src[14] = 1'b1; cycles(2); src[14] = 1'b0;
    rd_chk('h0A, 3'd2, 32'h4000, "R5 half read");
    rd_chk('h08, 3'd4, 32'd0, "R6 partial read clears");
    src[16] = 1'b1; cycles(2); src[16] = 1'b0;
    wr_reg('h08, 3'd4, 32'hFFFF_FFFF);
    rd_chk('h08, 3'd4, 32'd0, "R6 write ones clears");
    src[17] = 1'b1; cycles(2); src[17] = 1'b0;
    wr_reg('h08, 3'd4, 32'd0);
    rd_chk('h08, 3'd4, 32'd0, "R6 write zero clears");

    // R7 mask warning
    access(1'b1, 'h04, 3'd4, 32'h0000_0001, rd, er, wn, tc);
    check("R7 warn bad bit", {31'd0, wn}, 32'd1);
    rd_chk('h04, 3'd4, 32'h0000_0001, "R7 stored anyway");
    access(1'b1, 'h04, 3'd4, 32'hFFFF_FFFF, rd, er, wn, tc);
    check("R7 all ones no warn", {31'd0, wn}, 32'd0);
    access(1'b1, 'h04, 3'd4, 32'h003F_63A0, rd, er, wn, tc);
    check("R7 valid set no warn", {31'd0, wn}, 32'd0);
    wr_reg('h04, 3'd4, 32'd0);

    // R8 control
    access(1'b1, 'h0C, 3'd4, 32'hFFFF_FFFF, rd, er, wn, tc);
    check("R8 toc pulse", {31'd0, tc}, 32'd1);
    rd_chk('h0C, 3'd4, 32'h0000_0100, "R8 only bit8");
    access(1'b1, 'h0C, 3'd4, 32'h0000_0100, rd, er, wn, tc);
    check("R8 no toc", {31'd0, tc}, 32'd0);

    // R9 blocked by bus-error bit
    wr_reg('h04, 3'd4, 32'h0000_0100);
    src[8] = 1'b1; cycles(6); src[8] = 1'b0; cycles(2);
    wr_reg('h0C, 3'd4, 32'd0);
    rd_chk('h0C, 3'd4, 32'd0, "R8 cleared");

    // R9 normal delivery, then a masked source
    exp_q.push_back({32'h0000_F000, 32'h0000_0003});
    src[8] = 1'b1; cycles(6);
    check("R9 delivered", exp_q.size(), 32'd0);
    src[8] = 1'b0;
    src[9] = 1'b1; cycles(6); src[9] = 1'b0; cycles(2);

    // R10 hold and lowest-first ordering
    wr_ready = 1'b0;
    wr_reg('h10, 3'd4, 32'h1234_5671);
    wr_reg('h04, 3'd4, 32'h0020_00A0);
    exp_q.push_back({32'h1234_5660, 32'h0000_0011});
    src[7] = 1'b1; cycles(4);
    check("R10 valid held", {31'd0, wr_valid}, 32'd1);
    check("R10 addr", wr_addr, 32'h1234_5660);
    cycles(2);
    check("R10 addr stable", wr_addr, 32'h1234_5660);
    check("R10 data stable", wr_data, 32'h0000_0011);
    src[5] = 1'b1; src[21] = 1'b1; cycles(3);
    wr_reg('h10, 3'd4, 32'h0ABC_DE1F);
    exp_q.push_back({32'h0ABC_DE00, 32'h0000_001F});
    @(negedge clk); wr_ready = 1'b1;
    @(negedge clk); wr_ready = 1'b0;
    cycles(3);
    // source 5 must be in flight now; drop 21
    wr_reg('h04, 3'd4, 32'h0000_00A0);
    wr_ready = 1'b1; cycles(10);
    check("R10 lowest first, one each", exp_q.size(), 32'd0);
    src = '0; cycles(2);
    wr_reg('h10, 3'd4, IAR_DEF);

    // R11 system registers
    rd_chk('hC008, 3'd4, 32'd0, "R11 version");
    wr_reg('hC008, 3'd4, 32'h55);
    rd_chk('hC008, 3'd4, 32'd0, "R11 version write ignored");
    wr_reg('hC00C, 3'd4, 32'hFFFF_FFFF);
    rd_chk('hC00C, 3'd4, 32'd0, "R11 io reset");
    wr_reg('hC000, 3'd4, 32'h0000_0002);
    rd_chk('hC000, 3'd4, 32'h0000_0002, "R11 power");
    wr_reg('hC004, 3'd4, 32'hDEAD_BEEF);
    rd_chk('hC004, 3'd4, 32'hDEAD_BEEF, "R11 errlog");
    wr_reg('hC010, 3'd4, 32'h0000_5A5A);
    rd_chk('hC010, 3'd4, 32'h0000_5A5A, "R11 arb");

    cycles(4);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule